// File: doc/BRIEF.md
# Cycle Timestamp Counter with Coherent Split Read

This block gives one processor core a free-running cycle counter. Software reads it before and after a stretch of code, and the difference between the two readings is the number of clock cycles that stretch took. The count is 64 bits wide. It is seen through two 32-bit registers behind a minimal strobe-based register port: the low word is at word address 0 and the high word at word address 1.

After reset the counter holds zero and does not move. A write of any value to the low-word address arms it. The count starts from zero and then advances by one on every clock. Software has no way to halt, pause or reload a running counter. Only a synchronous reset stops and clears it, and after that a new write to the low word is needed to arm it again.

To read the 64-bit value without tearing, software reads the low word first. That read also copies the live high word into a shadow register. A later read of the high-word address returns this shadow copy, so the pair of words belongs to the same clock edge.

Top module: `tsc_timer`

## Requirements
- R1: While `rst` is high at a rising edge, the count is cleared, the counter is stopped, the high-word shadow is zero and `rdata` is zero. A stopped counter stays at zero.
- R2: A write (`wr_en`=1) to address 0 while the counter is stopped arms it. The `wdata` value is ignored, the count becomes zero at that edge, and a low-word read on the very next edge returns 0.
- R3: While armed, the 64-bit count increases by exactly one at every rising edge. Two low-word reads taken g idle cycles apart differ by g+1.
- R4: A write to address 0 while the counter runs has no effect. The count neither restarts nor pauses, and nothing except `rst` stops it.
- R5: Writes to address 1 and to any other address are ignored. They do not arm a stopped counter and do not change a running count or the shadow.
- R6: `rdata` is registered. A read (`rd_en`=1) sampled at a rising edge updates `rdata` at that edge. A low-word read returns bits [31:0] of the count as it stood just before that edge. With `rd_en` low, `rdata` holds its value.
- R7: A read of address 0 copies bits [63:32] of the same count value into a shadow register. A read of address 1 returns that shadow, not the live high word. The shadow changes only on a low-word read.
- R8: The count rolls over from all ones to zero silently and keeps counting.
- R9: A read of any address other than 0 and 1 returns zero.
- R10: A reset that arrives while the counter runs stops and clears it. Afterwards the counter stays at zero until a new write to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; the count advances on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| rd_en | input | 1 | Read strobe, sampled at the rising edge |
| addr | input | ADDR_W (2) | Word address: 0 low word, 1 high word |
| wdata | input | WORD_W (32) | Write data, ignored by this block |
| rdata | output | WORD_W (32) | Registered read data |

## Verification
A wrong step in the count or a broken carry between the words shows up in the very next pair of low-word reads, whose difference no longer equals the gap in cycles plus one. A carry fault may stay hidden until the low word rolls over, so the bench also uses a narrow-word instance that crosses a word boundary and wraps within a few hundred cycles. A run flag that drops, or a start that reloads, shows up as a difference that is too small or negative on the next read. A stale or live-tracking shadow appears on the first high-word read that follows a low-word read across a carry.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  // Register selected by a strobe's address
  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_NONE = 2'd2
  } tsc_sel_e;

  localparam int unsigned NUM_WORDS = 2;

endpackage

// File: rtl/tsc_arm.sv
module tsc_arm (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  output logic running,
  output logic start_pulse
);

  logic run_q;

  assign running     = run_q;
  assign start_pulse = start_req & ~run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
    end else if (start_req) begin
      run_q <= 1'b1;
    end
  end

  // R4: once armed only reset may clear the run flag
  a_r4_no_stop: assert property (@(posedge clk) disable iff (rst)
    run_q |=> run_q);

  // R2: a start request arms the counter on the next edge
  a_r2_arms: assert property (@(posedge clk) disable iff (rst)
    start_req |=> run_q);

endmodule

// File: rtl/tsc_word.sv
module tsc_word #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         inc_in,
  output logic [W-1:0] q,
  output logic         carry_out
);

  logic [W-1:0] q_r;

  assign q         = q_r;
  assign carry_out = inc_in & (&q_r);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      q_r <= '0;
    end else if (inc_in) begin
      q_r <= q_r + W'(1);
    end
  end

  // R8: a word wraps from all ones to zero and raises its carry
  a_r8_word_wrap: assert property (@(posedge clk) disable iff (rst || clear)
    (inc_in && (&q_r)) |=> (q_r == '0));

endmodule

// File: rtl/tsc_regport.sv
module tsc_regport
  import tsc_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_en,
  input  tsc_sel_e              sel,
  input  logic [2*WORD_W-1:0]   count,
  output logic [WORD_W-1:0]     rdata
);

  logic [WORD_W-1:0] shadow_q;
  logic [WORD_W-1:0] rdata_q;

  assign rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      rdata_q  <= '0;
    end else if (rd_en) begin
      unique case (sel)
        SEL_LO: begin
          rdata_q  <= count[WORD_W-1:0];
          shadow_q <= count[2*WORD_W-1:WORD_W];
        end
        SEL_HI:  rdata_q <= shadow_q;
        default: rdata_q <= '0;
      endcase
    end
  end

  // R7: the shadow moves only on a low-word read
  a_r7_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && sel == SEL_LO) |=> $stable(shadow_q));

  // R6: read data holds while no read is strobed
  a_r6_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata_q));

  // R9: unmapped addresses read as zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_NONE) |=> (rdata_q == '0));

endmodule

// File: rtl/tsc_timer.sv
module tsc_timer
  import tsc_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  localparam int unsigned CNT_W = NUM_WORDS * WORD_W;

  tsc_sel_e           sel;
  logic               running;
  logic               start_pulse;
  logic [NUM_WORDS:0] inc_chain;
  logic [CNT_W-1:0]   count;
  logic               wdata_unused;

  // The written value carries no meaning for this block
  assign wdata_unused = ^wdata;

  always_comb begin
    if (addr == ADDR_W'(0))      sel = SEL_LO;
    else if (addr == ADDR_W'(1)) sel = SEL_HI;
    else                         sel = SEL_NONE;
  end

  tsc_arm u_arm (
    .clk         (clk),
    .rst         (rst),
    .start_req   (wr_en && (sel == SEL_LO)),
    .running     (running),
    .start_pulse (start_pulse)
  );

  assign inc_chain[0] = running;

  generate
    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
      tsc_word #(.W(WORD_W)) u_word (
        .clk       (clk),
        .rst       (rst),
        .clear     (start_pulse),
        .inc_in    (inc_chain[i]),
        .q         (count[i*WORD_W +: WORD_W]),
        .carry_out (inc_chain[i+1])
      );
    end
  endgenerate

  tsc_regport #(.WORD_W(WORD_W)) u_port (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_en),
    .sel   (sel),
    .count (count),
    .rdata (rdata)
  );

  // R3: a running count advances by exactly one per edge (wrap included, R8)
  a_r3_step_one: assert property (@(posedge clk) disable iff (rst)
    running |=> (count == $past(count) + CNT_W'(1)));

  // R1: a stopped counter that is not being armed stays at zero
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (!running && !start_pulse) |=> (count == '0));

  // R2: arming loads zero
  a_r2_start_zero: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> (running && count == '0));

endmodule

// File: tb/tsc_timer_test.sv
module tsc_timer_test;

  localparam int CLK_PERIOD = 10;
  localparam int NGAP = 6;
  localparam int GAPS [NGAP] = '{0, 1, 3, 7, 16, 40};

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [3:0]  rdata_s;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsc_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata));

  // Narrow instance: 8-bit count, so carries and wrap happen quickly
  tsc_timer #(.WORD_W(4)) uut_small (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata[3:0]), .rdata(rdata_s));

  // Behaviour model written from the requirements
  logic        m_run;
  logic [63:0] m_cnt;

  always @(posedge clk) begin
    if (rst) begin
      m_run <= 1'b0;
      m_cnt <= '0;
    end else if (wr_en && addr == 2'd0 && !m_run) begin
      m_run <= 1'b1;
      m_cnt <= '0;
    end else if (m_run) begin
      m_cnt <= m_cnt + 64'd1;
    end
  end

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic do_write(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [31:0] v,
                         output logic [3:0] vs, output logic [63:0] snap);
    snap = m_cnt;
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v  = rdata;
    vs = rdata_s;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a, b, hi;
    logic [3:0]  as, bs;
    logic [63:0] sa, sb;

    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1: reset state and a stopped counter
    check(rdata == 0, "R1 rdata after reset", rdata, 0);
    idle(10);
    do_read(2'd0, a, as, sa);
    check(a == 0, "R1 stopped low word", a, 0);
    do_read(2'd1, a, as, sa);
    check(a == 0, "R1 shadow after reset", a, 0);

    // R5: writes to high and unmapped addresses do not arm
    do_write(2'd1, 32'h1234_5678);
    do_write(2'd3, 32'hFFFF_FFFF);
    idle(5);
    do_read(2'd0, a, as, sa);
    check(a == 0, "R5 high write did not arm", a, 0);

    // R2: arm with arbitrary data, first read returns zero
    do_write(2'd0, 32'hDEAD_BEEF);
    do_read(2'd0, a, as, sa);
    check(a == 0, "R2 first read after arm", a, 0);

    // R3/R6: table of read gaps walked by one loop
    for (int i = 0; i < NGAP; i++) begin
      do_read(2'd0, a, as, sa);
      idle(GAPS[i]);
      do_read(2'd0, b, bs, sb);
      check(b - a == GAPS[i] + 1, "R3 step per cycle", b - a, GAPS[i] + 1);
      check(b == sb[31:0], "R6 low read value", b, sb[31:0]);
    end

    // R4: write to low while running neither restarts nor pauses
    do_read(2'd0, a, as, sa);
    do_write(2'd0, 32'h0);
    do_read(2'd0, b, bs, sb);
    check(b - a == 2, "R4 running write ignored", b - a, 2);

    // R5: write to high while running changes nothing
    do_write(2'd1, 32'hAAAA_AAAA);
    do_read(2'd0, a, as, sa);
    check(a - b == 2, "R5 high write while running", a - b, 2);
    do_read(2'd1, hi, bs, sb);
    check(hi == 0, "R5 shadow untouched", hi, 0);

    // R9: unmapped address reads zero
    do_read(2'd2, a, as, sa);
    check(a == 0, "R9 unmapped read", a, 0);

    // R6: rdata holds with no read strobe
    do_read(2'd0, a, as, sa);
    idle(4);
    check(rdata == a, "R6 rdata holds", rdata, a);

    // R7: shadow is captured at the low read, not tracked live (narrow)
    while (m_cnt[3:0] != 4'hE) idle(1);
    do_read(2'd0, a, as, sa);
    idle(3);
    do_read(2'd1, a, bs, sb);
    check(bs == sa[7:4], "R7 shadow from low read", bs, sa[7:4]);
    check(m_cnt[7:4] != sa[7:4], "R7 live high moved on", m_cnt[7:4], sa[7:4] + 1);

    // R8: narrow count wraps 0xFF -> 0x00
    while (m_cnt[7:0] != 8'hFE) idle(1);
    do_read(2'd0, a, as, sa);
    check(as == 4'hE, "R8 low before wrap", as, 4'hE);
    do_read(2'd0, a, as, sa);
    check(as == 4'hF, "R8 low at all ones", as, 4'hF);
    do_read(2'd1, a, bs, sb);
    check(bs == 4'hF, "R8 high at all ones", bs, 4'hF);
    do_read(2'd0, a, as, sa);
    check(as == 4'h1, "R8 low after wrap", as, 4'h1);
    do_read(2'd1, a, bs, sb);
    check(bs == 4'h0, "R8 high after wrap", bs, 4'h0);

    // R10: reset mid-run stops and clears; re-arm needed
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(6);
    do_read(2'd0, a, as, sa);
    check(a == 0, "R10 stopped after reset", a, 0);
    check(as == 0, "R10 narrow stopped", as, 0);
    do_write(2'd0, 32'h5);
    idle(9);
    do_read(2'd0, a, as, sa);
    check(a == 9, "R10 re-armed count", a, 9);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule